// File: doc/BRIEF.md
# Three-Die Random Roller

The block rolls three dice for a push-button game. Each die owns a pseudo-random source: a maximal-length shift register with XOR feedback. The three registers have lengths that share no common factor, so their sequences stay uncorrelated over any practical observation window. All three registers advance on every clock from the moment reset is released, whether or not a roll is in progress.

A roll request makes each die take a 3-bit draw from the low bits of its register. The register has shifted three times since the previous draw of that die, so every draw holds fresh bits only. A draw of 6 or 7 is thrown away and the die waits three more shifts before drawing again. Values 0 to 5 therefore stay equally likely, but a roll has no fixed length. The block reports completion with a one-cycle strobe. At that strobe it updates three face values (1 to 6) and three 7-LED pip patterns. The pip LEDs sit at the positions of the one-face and six-face superimposed.

The request is a plain control pin and the strobe is a plain status pulse. The strobe cannot be stalled: nothing holds it for a receiver. The face and pip outputs keep their values until the next strobe, so a receiver that misses the pulse can still read the last result.

Top module: `dice_roller`

## Requirements
- R1: During and after synchronous reset, `roll_valid` is 0 and all three face values and all three pip patterns are 0 (blank) until the first completed roll.
- R2: Die A uses a 17-bit register with seed 0x12345 and feedback from bits 16 and 13. Die B uses 19 bits, seed 0x5A5A5, feedback from bits 18, 17, 16 and 13. Die C uses 23 bits, seed 0x3CBEEF, feedback from bits 22 and 17. Reset loads the seed. Every clock after that, each register shifts toward its MSB and takes the XOR of its feedback bits into bit 0.
- R3: A request is accepted at a clock edge where `roll_req` is 1 and no roll is in progress. Each die takes its first draw at the third edge after acceptance, and any later draws every third edge after that. A draw is bits [2:0] of the die's register as they stand just before that edge.
- R4: A draw of 6 or 7 is rejected, and that die draws again three edges later. A draw of 0 to 5 ends the search for that die.
- R5: The reported face value of a die is its accepted draw plus one, in the range 1 to 6.
- R6: `roll_valid` goes high for exactly one cycle, one edge after the edge at which the last of the three dice accepts its draw. Faces and pips take their new values in that same cycle.
- R7: Pip bits are {6:TL, 5:TR, 4:ML, 3:C, 2:MR, 1:BL, 0:BR}. The patterns are: face 1 = 0001000, 2 = 1000001, 3 = 1001001, 4 = 1100011, 5 = 1101011, 6 = 1110111.
- R8: A request made while a roll is in progress is ignored: it changes neither the draws, nor the completion time, nor the results of that roll, and it starts no further roll.
- R9: Face values and pip patterns hold their values in every cycle in which `roll_valid` is 0.
- R10: No pseudo-random register ever holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roll_req | input | 1 | Debounced roll request |
| roll_valid | output | 1 | One-cycle strobe when all three dice are set |
| die_a | output | 3 | Face value of die A (0 after reset, then 1..6) |
| die_b | output | 3 | Face value of die B |
| die_c | output | 3 | Face value of die C |
| pips_a | output | 7 | Pip LED pattern of die A |
| pips_b | output | 7 | Pip LED pattern of die B |
| pips_c | output | 7 | Pip LED pattern of die C |

## Verification
The bench builds the block with its default parameters: a draw spacing of 3 and register lengths of 17, 19 and 23. Because the seeds are fixed, the bench can track all three registers and predict, roll by roll, how many draws each die rejects, when the strobe arrives and which faces it brings. Across about sixty rolls the rejection chains differ in length from die to die. The last die to finish changes from roll to roll, and requests that land mid-roll reach every cycle of the waiting window.

// File: rtl/dice_pkg.sv
package dice_pkg;
  localparam int NUM_DICE = 3;
  localparam int DRAW_W   = 3;
  localparam int PIP_W    = 7;
  localparam int FACE_MAX = 6;

  localparam int          DIE_LEN  [NUM_DICE] = '{17, 19, 23};
  localparam logic [31:0] DIE_TAPS [NUM_DICE] = '{32'h0001_2000, 32'h0007_2000, 32'h0042_0000};
  localparam logic [31:0] DIE_SEED [NUM_DICE] = '{32'h0001_2345, 32'h0005_A5A5, 32'h003C_BEEF};

  typedef logic [DRAW_W-1:0] face_t;
  typedef logic [PIP_W-1:0]  pips_t;
endpackage

// File: rtl/dice_lfsr.sv
module dice_lfsr #(
  parameter int          WIDTH = 17,
  parameter logic [31:0] TAPS  = 32'h0001_2000,
  parameter logic [31:0] SEED  = 32'h0001_2345
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] TAP_MASK  = TAPS[WIDTH-1:0];
  localparam logic [WIDTH-1:0] SEED_BITS = SEED[WIDTH-1:0];

  logic feedback;
  assign feedback = ^(state & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst) state <= SEED_BITS;
    else     state <= {state[WIDTH-2:0], feedback};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R10
  AST_LFSR_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state[WIDTH-1:1] == $past(state[WIDTH-2:0])); // R2
endmodule

// File: rtl/dice_lane.sv
module dice_lane
  import dice_pkg::*;
#(
  parameter int          WIDTH   = 17,
  parameter logic [31:0] TAPS    = 32'h0001_2000,
  parameter logic [31:0] SEED    = 32'h0001_2345,
  parameter int          SPACING = DRAW_W
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output logic  done,
  output face_t face
);
  localparam int CNT_W = (SPACING > 1) ? $clog2(SPACING) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SPACING - 1);

  logic [WIDTH-1:0] rng;
  logic [CNT_W-1:0] cnt;
  logic             searching;
  face_t            draw;
  logic             legal;

  dice_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_rng (
    .clk   (clk),
    .rst   (rst),
    .state (rng)
  );

  assign draw  = rng[DRAW_W-1:0];
  assign legal = (draw < face_t'(FACE_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      searching <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      face      <= '0;
    end else if (start) begin
      searching <= 1'b1;
      done      <= 1'b0;
      cnt       <= '0;
    end else if (searching) begin
      if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (legal) begin
          face      <= draw + face_t'(1);
          searching <= 1'b0;
          done      <= 1'b1;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_FACE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (face >= face_t'(1) && face <= face_t'(FACE_MAX))); // R5
  AST_ACCEPT_FROM_SEARCH: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(searching)); // R3
  AST_FACE_STEADY: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> $stable(face)); // R4
endmodule

// File: rtl/dice_pips.sv
module dice_pips
  import dice_pkg::*;
(
  input  face_t face,
  output pips_t pips
);
  logic odd_face, two_up, four_up, six_face;

  assign odd_face = face[0];
  assign two_up   = (face >= face_t'(2)) && (face <= face_t'(FACE_MAX));
  assign four_up  = (face >= face_t'(4)) && (face <= face_t'(FACE_MAX));
  assign six_face = (face == face_t'(FACE_MAX));

  // {TL, TR, ML, C, MR, BL, BR}
  assign pips = {two_up, four_up, six_face, odd_face && (face <= face_t'(5)),
                 six_face, four_up, two_up};
endmodule

// File: rtl/dice_roller.sv
module dice_roller
  import dice_pkg::*;
#(
  parameter int SPACING = DRAW_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       roll_req,
  output logic       roll_valid,
  output logic [2:0] die_a,
  output logic [2:0] die_b,
  output logic [2:0] die_c,
  output logic [6:0] pips_a,
  output logic [6:0] pips_b,
  output logic [6:0] pips_c
);
  logic                rolling;
  logic                start;
  logic [NUM_DICE-1:0] lane_done;
  face_t               lane_face [NUM_DICE];
  pips_t               lane_pips [NUM_DICE];
  face_t               face_q    [NUM_DICE];
  pips_t               pips_q    [NUM_DICE];
  logic                finish;

  assign start  = roll_req && !rolling;
  assign finish = rolling && (&lane_done);

  for (genvar i = 0; i < NUM_DICE; i++) begin : g_die
    dice_lane #(
      .WIDTH   (DIE_LEN[i]),
      .TAPS    (DIE_TAPS[i]),
      .SEED    (DIE_SEED[i]),
      .SPACING (SPACING)
    ) u_lane (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .done  (lane_done[i]),
      .face  (lane_face[i])
    );

    dice_pips u_pips (
      .face (lane_face[i]),
      .pips (lane_pips[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        face_q[i] <= '0;
        pips_q[i] <= '0;
      end else if (finish) begin
        face_q[i] <= lane_face[i];
        pips_q[i] <= lane_pips[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rolling    <= 1'b0;
      roll_valid <= 1'b0;
    end else begin
      roll_valid <= finish;
      if (start)       rolling <= 1'b1;
      else if (finish) rolling <= 1'b0;
    end
  end

  assign die_a  = face_q[0];
  assign die_b  = face_q[1];
  assign die_c  = face_q[2];
  assign pips_a = pips_q[0];
  assign pips_b = pips_q[1];
  assign pips_c = pips_q[2];

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    roll_valid |=> !roll_valid); // R6
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !roll_valid |-> $stable({die_a, die_b, die_c, pips_a, pips_b, pips_c})); // R9
  AST_VALID_ENDS_ROLL: assert property (@(posedge clk) disable iff (rst)
    roll_valid |-> ($past(rolling) && !rolling)); // R8
  AST_CENTER_PIP_ODD: assert property (@(posedge clk) disable iff (rst)
    roll_valid |-> (pips_a[3] == die_a[0] && pips_b[3] == die_b[0] && pips_c[3] == die_c[0])); // R7
  AST_PIP_COUNT: assert property (@(posedge clk) disable iff (rst)
    roll_valid |-> ($countones(pips_a) == int'(die_a))); // R7
endmodule

// File: tb/dice_roller_tb.sv
module dice_roller_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       roll_req = 1'b0;
  logic       roll_valid;
  logic [2:0] die_a, die_b, die_c;
  logic [6:0] pips_a, pips_b, pips_c;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #2ns clk = ~clk;

  dice_roller u_dut (
    .clk(clk), .rst(rst), .roll_req(roll_req), .roll_valid(roll_valid),
    .die_a(die_a), .die_b(die_b), .die_c(die_c),
    .pips_a(pips_a), .pips_b(pips_b), .pips_c(pips_c)
  );

  // Bench model of the sources, from R2
  localparam int          M_LEN  [3] = '{17, 19, 23};
  localparam logic [31:0] M_TAPS [3] = '{(32'd1 << 16) | (32'd1 << 13),
                                         (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 16) | (32'd1 << 13),
                                         (32'd1 << 22) | (32'd1 << 17)};
  localparam logic [31:0] M_SEED [3] = '{32'h12345, 32'h5A5A5, 32'h3CBEEF};

  logic [31:0] model [3];

  function automatic logic [31:0] step(input logic [31:0] s, input int len, input logic [31:0] taps);
    logic [31:0] mask;
    mask = (32'd1 << len) - 32'd1;
    return ((s << 1) | {31'd0, ^(s & taps)}) & mask;
  endfunction

  function automatic logic [6:0] pip_of(input int f);
    case (f)
      1: return 7'b0001000;
      2: return 7'b1000001;
      3: return 7'b1001001;
      4: return 7'b1100011;
      5: return 7'b1101011;
      6: return 7'b1110111;
      default: return 7'b0000000;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++)
      model[i] <= rst ? M_SEED[i] : step(model[i], M_LEN[i], M_TAPS[i]);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Given the register value seen just after the accepting edge,
  // return the edge index of acceptance and the face (R3, R4, R5).
  task automatic predict(input logic [31:0] s0, input int d, output int edge_idx, output int face);
    logic [31:0] s;
    s = step(step(s0, M_LEN[d], M_TAPS[d]), M_LEN[d], M_TAPS[d]);
    edge_idx = 3;
    face = 0;
    for (int n = 0; n < 2000; n++) begin
      if (s[2:0] < 3'd6) begin
        face = int'(s[2:0]) + 1;
        break;
      end
      for (int j = 0; j < 3; j++) s = step(s, M_LEN[d], M_TAPS[d]);
      edge_idx += 3;
    end
  endtask

  int last_face [3] = '{0, 0, 0};

  task automatic check_outputs(input string req, input int f0, input int f1, input int f2);
    check(req, "die_a", int'(die_a), f0);
    check(req, "die_b", int'(die_b), f1);
    check(req, "die_c", int'(die_c), f2);
    check(req, "pips_a", int'(pips_a), int'(pip_of(f0)));
    check(req, "pips_b", int'(pips_b), int'(pip_of(f1)));
    check(req, "pips_c", int'(pips_c), int'(pip_of(f2)));
  endtask

  task automatic do_roll(input bit noisy);
    int t_acc [3];
    int f_new [3];
    int t_last;
    logic [31:0] snap [3];
    roll_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    roll_req = 1'b0;
    for (int i = 0; i < 3; i++) snap[i] = model[i];
    t_last = 0;
    for (int i = 0; i < 3; i++) begin
      predict(snap[i], i, t_acc[i], f_new[i]);
      if (t_acc[i] > t_last) t_last = t_acc[i];
    end
    for (int k = 1; k <= t_last + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k <= t_last) begin
        check("R6", "roll_valid before completion", int'(roll_valid), 0);
        check_outputs("R9", last_face[0], last_face[1], last_face[2]);
        roll_req = noisy ? (($urandom % 3) == 0) : 1'b0;   // R8 ignored requests
      end else begin
        check("R6", "roll_valid at completion", int'(roll_valid), 1);
        check_outputs("R5/R7", f_new[0], f_new[1], f_new[2]);
        roll_req = 1'b0;
      end
    end
    for (int i = 0; i < 3; i++) last_face[i] = f_new[i];
    @(posedge clk);
    @(negedge clk);
    check("R6", "roll_valid one cycle", int'(roll_valid), 0);
    check("R8", "no extra roll after ignored requests", int'(roll_valid), 0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9", "roll_valid idle", int'(roll_valid), 0);
      check_outputs("R9", last_face[0], last_face[1], last_face[2]);
    end
  endtask

  initial begin
    void'($urandom(32'd7531));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "roll_valid in reset", int'(roll_valid), 0);
    check_outputs("R1", 0, 0, 0);
    rst = 1'b0;
    idle(5);
    check("R1", "blank after reset", int'(pips_a | pips_b | pips_c), 0);
    // R10: sources stay nonzero per the bench model of R2
    check("R10", "model nonzero", int'(model[0] != 0 && model[1] != 0 && model[2] != 0), 1);
    do_roll(1'b0);              // directed: clean request
    do_roll(1'b0);              // directed: back-to-back roll
    do_roll(1'b1);              // directed: noisy request line during roll
    for (int r = 0; r < 60; r++) begin
      idle($urandom % 6);
      do_roll($urandom % 2 == 1);
    end
    done_run = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule